// File: doc/BRIEF.md
# Fourteen-Source Interrupt Aggregator

This block gathers fourteen single-cycle event pulses into one interrupt line. Each pulse sets a sticky bit in a status register. A mask register picks which sticky bits may drive the line, and the line is the registered OR of the status bits that are unmasked. Software reaches the block over a small register bus with one request per cycle. Reading the status register returns the pending events and clears them in the same access. Two write-one registers, one to enable and one to disable, change the mask. A fourth register reads the mask back, where a 1 marks a source that is disabled.

The bus has a valid strobe, a write flag, a 2-bit address and a write data word. A read answers one cycle after the request, with a read-valid pulse beside the data. The register addresses are: 0 status (read-to-clear), 1 enable (write-one), 2 disable (write-one), 3 mask (read). Bit i of each register belongs to event source i. Write data bits above the source count are ignored, and read data bits above the source count are zero. The asynchronous reset is released to the internal logic through a two-flop synchronizer, so the block is ready on the third rising edge after `rst_n` goes high.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the status register is all zeros, every mask bit is 1 (all sources disabled), and `irq_o` and `bus_rvalid_o` are 0.
- R2: A 1 on `evt_i[i]` at a rising edge sets status bit i. The bit stays set until a status read clears it, and further pulses on that source have no extra effect.
- R3: A read request to address 0 yields `bus_rvalid_o`=1 on the next cycle, with `bus_rdata_o` holding the status as it was before the request edge. The bits returned are cleared at that edge.
- R4: An event that arrives at the same edge as a status read is not part of that read's data and stays latched for the next read.
- R5: A write to address 1 clears each mask bit whose write data bit is 1. Mask bits whose write data bit is 0 keep their value.
- R6: A write to address 2 sets each mask bit whose write data bit is 1. Mask bits whose write data bit is 0 keep their value. Inside the mask logic, a bit that is asked to be both enabled and disabled at one edge ends up disabled.
- R7: A read request to address 3 returns the mask on the next cycle, with 1 meaning disabled. The read has no side effect.
- R8: `irq_o` is 1 exactly when, one cycle earlier, some status bit was 1 while its mask bit was 0.
- R9: Writes to addresses 0 and 3 change nothing. Reads of addresses 1 and 2 return zero and clear nothing. Only a read of address 0 clears status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 14 | Event pulses, one bit per source |
| bus_valid_i | input | 1 | Register request strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read response, one cycle after a read request |
| irq_o | output | 1 | Aggregated interrupt |

## Verification
The embedded assertions check a set of properties on every cycle:
- a pending bit stays set unless a clear is requested;
- an arriving event is always latched, even at the edge of a clearing read;
- enable and disable writes move exactly the mask bits they name;
- the line follows the unmasked status with one cycle of delay;
- writes never clear status.

Some behaviours can only be shown by the bench's scenarios and its per-cycle reference model:
- the read data value, including the pre-clear snapshot when an event collides with a read;
- the polarity and content of the mask readback;
- the zero reads of the write-only addresses;
- the reset values seen at the ports.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int unsigned REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_PENDING = 2'd0,
    REG_SET_EN  = 2'd1,
    REG_SET_DIS = 2'd2,
    REG_MASK_RD = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_sync_n = pipe_q[STAGES-1];

endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 14,
  parameter int unsigned DATA_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_valid_i,
  input  logic                  bus_write_i,
  input  logic [REG_ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0]     bus_wdata_i,
  input  logic [NUM_SRC-1:0]    status_i,
  input  logic [NUM_SRC-1:0]    mask_i,
  output logic [NUM_SRC-1:0]    clr_o,
  output logic [NUM_SRC-1:0]    en_o,
  output logic [NUM_SRC-1:0]    dis_o,
  output logic [DATA_W-1:0]     bus_rdata_o,
  output logic                  bus_rvalid_o
);

  logic              rd_req;
  logic              wr_req;
  reg_sel_e          sel;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              rvalid_d, rvalid_q;

  always_comb begin
    sel    = reg_sel_e'(bus_addr_i);
    rd_req = bus_valid_i && !bus_write_i;
    wr_req = bus_valid_i &&  bus_write_i;
    clr_o  = '0;
    en_o   = '0;
    dis_o  = '0;
    if (rd_req && sel == REG_PENDING) clr_o = status_i;
    if (wr_req && sel == REG_SET_EN)  en_o  = bus_wdata_i[NUM_SRC-1:0];
    if (wr_req && sel == REG_SET_DIS) dis_o = bus_wdata_i[NUM_SRC-1:0];
  end

  always_comb begin
    rvalid_d = rd_req;
    rdata_d  = '0;
    if (rd_req) begin
      case (sel)
        REG_PENDING: rdata_d[NUM_SRC-1:0] = status_i;
        REG_MASK_RD: rdata_d[NUM_SRC-1:0] = mask_i;
        default:     rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;

  // R3
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_i && !bus_write_i) |=> bus_rvalid_o);

  // R9
  wr_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_i && bus_write_i) |-> (clr_o == '0));

endmodule

// File: rtl/irq_status_latch.sv
module irq_status_latch #(
  parameter int unsigned NUM_SRC = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] status_o
);

  logic [NUM_SRC-1:0] status_d, status_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    always_comb begin
      status_d[g] = evt_i[g] | (status_q[g] & ~clr_i[g]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status_o = status_q;

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i == '0) |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R4
  evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
  parameter int unsigned NUM_SRC = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] dis_i,
  output logic [NUM_SRC-1:0] mask_o
);

  logic [NUM_SRC-1:0] mask_d, mask_q;
  logic               upd;

  always_comb begin
    upd    = |(en_i | dis_i);
    mask_d = (mask_q & ~en_i) | dis_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mask_q <= '1;
    else if (upd) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  // R5
  enable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(en_i & ~dis_i)) |=> ((mask_q & $past(en_i & ~dis_i)) == '0));

  // R6
  disable_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dis_i) |=> ((mask_q & $past(dis_i)) == $past(dis_i)));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_i == '0) && (dis_i == '0)) |=> $stable(mask_q));

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int unsigned NUM_SRC = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic               irq_o
);

  logic irq_d, irq_q;

  always_comb begin
    irq_d = |(status_i & ~mask_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_i & ~mask_i)) |=> irq_o);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_i & ~mask_i) == '0) |=> !irq_o);

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 14,
  parameter int unsigned DATA_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SRC-1:0]    evt_i,
  input  logic                  bus_valid_i,
  input  logic                  bus_write_i,
  input  logic [REG_ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0]     bus_wdata_i,
  output logic [DATA_W-1:0]     bus_rdata_o,
  output logic                  bus_rvalid_o,
  output logic                  irq_o
);

  localparam int unsigned SYNC_STAGES = 2;

  logic               rst_int_n;
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] clr;
  logic [NUM_SRC-1:0] en_bits;
  logic [NUM_SRC-1:0] dis_bits;

  irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  irq_reg_decode #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_dec (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .bus_valid_i  (bus_valid_i),
    .bus_write_i  (bus_write_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .status_i     (status),
    .mask_i       (mask),
    .clr_o        (clr),
    .en_o         (en_bits),
    .dis_o        (dis_bits),
    .bus_rdata_o  (bus_rdata_o),
    .bus_rvalid_o (bus_rvalid_o)
  );

  irq_status_latch #(.NUM_SRC(NUM_SRC)) u_stat (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .evt_i    (evt_i),
    .clr_i    (clr),
    .status_o (status)
  );

  irq_mask_ctrl #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .en_i   (en_bits),
    .dis_i  (dis_bits),
    .mask_o (mask)
  );

  irq_out_stage #(.NUM_SRC(NUM_SRC)) u_out (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .status_i (status),
    .mask_i   (mask),
    .irq_o    (irq_o)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    (!rst_int_n) |-> (!irq_o && !bus_rvalid_o));

endmodule

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;

  localparam int NSRC = 14;
  localparam int DW   = 16;
  localparam int FULL = (1 << NSRC) - 1;

  logic            clk;
  logic            rst_n;
  logic [NSRC-1:0] evt;
  logic            bvalid;
  logic            bwrite;
  logic [1:0]      baddr;
  logic [DW-1:0]   bwdata;
  logic [DW-1:0]   brdata;
  logic            brvalid;
  logic            irq;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  int m_status, m_mask, m_rdata, m_rvalid, m_irq, m_last_addr;

  irq_aggregator dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_i        (evt),
    .bus_valid_i  (bvalid),
    .bus_write_i  (bwrite),
    .bus_addr_i   (baddr),
    .bus_wdata_i  (bwdata),
    .bus_rdata_o  (brdata),
    .bus_rvalid_o (brvalid),
    .irq_o        (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_status = 0; m_mask = FULL; m_rdata = 0; m_rvalid = 0; m_irq = 0; m_last_addr = 0;
  endtask

  task automatic idle_inputs();
    evt = '0; bvalid = 1'b0; bwrite = 1'b0; baddr = '0; bwdata = '0;
  endtask

  // one clock: model the edge from current inputs, then compare at the falling edge
  task automatic cycle();
    int rd, clr, en, dis, n_status, n_mask, n_rdata, n_irq;
    @(posedge clk);
    rd  = (bvalid && !bwrite) ? 1 : 0;
    clr = (rd != 0 && baddr == 2'd0) ? m_status : 0;
    n_rdata = 0;
    if (rd != 0) begin
      if (baddr == 2'd0)      n_rdata = m_status;
      else if (baddr == 2'd3) n_rdata = m_mask;
      m_last_addr = int'(baddr);
    end
    n_irq = ((m_status & ~m_mask & FULL) != 0) ? 1 : 0;
    n_status = (m_status & ~clr) | int'(evt);
    en  = (bvalid && bwrite && baddr == 2'd1) ? (int'(bwdata) & FULL) : 0;
    dis = (bvalid && bwrite && baddr == 2'd2) ? (int'(bwdata) & FULL) : 0;
    n_mask = (m_mask & ~en) | dis;
    m_status = n_status; m_mask = n_mask; m_rdata = n_rdata;
    m_rvalid = rd; m_irq = n_irq;
    @(negedge clk);
    check("R8 irq", int'(irq), m_irq);
    check("R3 rvalid", int'(brvalid), m_rvalid);
    if (m_rvalid != 0) begin
      if (m_last_addr == 0)      check("R3 status read", int'(brdata), m_rdata);
      else if (m_last_addr == 3) check("R7 mask read", int'(brdata), m_rdata);
      else                       check("R9 write-only read", int'(brdata), 0);
    end
  endtask

  task automatic bus_read(input int a);
    bvalid = 1'b1; bwrite = 1'b0; baddr = 2'(a);
    cycle();
    bvalid = 1'b0;
  endtask

  task automatic bus_write(input int a, input int d);
    bvalid = 1'b1; bwrite = 1'b1; baddr = 2'(a); bwdata = DW'(d);
    cycle();
    bvalid = 1'b0; bwrite = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle_inputs();
    model_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs at reset
    check("R1 irq at reset", int'(irq), 0);
    check("R1 rvalid at reset", int'(brvalid), 0);
    rst_n = 1'b1;
    repeat (4) cycle();

    // R1 / R7: mask reads all ones after reset
    bus_read(3);
    check("R1 mask reset value", int'(brdata), FULL);
    bus_read(0);
    check("R1 status reset value", int'(brdata), 0);

    // R2: events latch while masked, no interrupt
    evt = 14'h0005; cycle();
    evt = 14'h0100; cycle();
    evt = 14'h0004; cycle();
    evt = '0; cycle(); cycle();
    check("R8 masked no irq", int'(irq), 0);
    bus_read(0);
    check("R2 latched bits", int'(brdata), 16'h0105);
    bus_read(0);
    check("R3 cleared after read", int'(brdata), 0);

    // R5: enable bits 0 and 8, zeros ignored
    bus_write(1, 16'h0101);
    bus_read(3);
    check("R5 mask after enable", int'(brdata), FULL & ~16'h0101);
    evt = 14'h0001; cycle();
    evt = '0; cycle(); cycle();
    check("R8 irq raised", int'(irq), 1);
    bus_read(0);
    check("R3 read returns pending", int'(brdata), 16'h0001);
    cycle(); cycle();
    check("R8 irq falls after clear", int'(irq), 0);

    // R4: event collides with a status read
    evt = 14'h0002; cycle();
    evt = 14'h0100; bvalid = 1'b1; bwrite = 1'b0; baddr = 2'd0;
    cycle();
    bvalid = 1'b0; evt = '0;
    check("R4 read excludes same-edge event", int'(brdata), 16'h0002);
    cycle();
    check("R4 colliding event raises irq", int'(irq), 1);
    bus_read(0);
    check("R4 event kept for next read", int'(brdata), 16'h0100);

    // R6: disable bit 8, upper data bits ignored
    bus_write(2, 16'hC100);
    bus_read(3);
    check("R6 mask after disable", int'(brdata), FULL & ~16'h0001);
    evt = 14'h0100; cycle(); evt = '0; cycle(); cycle();
    check("R6 disabled source silent", int'(irq), 0);

    // R9: writes to status and mask addresses have no effect
    bus_write(0, 16'hFFFF);
    bus_write(3, 16'h0000);
    bus_read(3);
    check("R9 mask unchanged", int'(brdata), FULL & ~16'h0001);
    bus_read(1);
    check("R9 enable reads zero", int'(brdata), 0);
    bus_read(2);
    check("R9 disable reads zero", int'(brdata), 0);
    bus_read(0);
    check("R9 status kept by other accesses", int'(brdata), 16'h0100);

    // mixed traffic against the model
    for (int i = 0; i < 600; i++) begin
      evt    = NSRC'($urandom & $urandom);
      bvalid = ($urandom % 3) == 0;
      bwrite = $urandom % 2;
      baddr  = 2'($urandom % 4);
      bwdata = DW'($urandom);
      cycle();
    end
    idle_inputs();
    cycle(); cycle();
    finish_run();
  end

endmodule